// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a 24-bit bank of general-purpose input pins, arranged as three groups of eight. It raises one interrupt request for each group. Each pin passes through a two-flop synchroniser. A rising or falling level change on a pin whose per-pin enable bit is set latches a sticky flag for that pin's group. The request to the processor for a group is asserted only while three bits are all one: the group flag, the group's enable bit and a global interrupt-enable input.

The middle group has only seven usable pins. Its top pin, bit 15 of the pin bus, cannot be enabled, so it never affects anything. Software reaches the registers over a byte-wide register bus with an address, a write strobe, write data and combinational read data. There are three pin-enable registers, a group-enable register and a flag register. A group flag clears in either of two ways: when the processor services the group, which is signalled by a one-cycle acknowledge pulse, or when software writes a one to the flag's bit. A new enabled change in the same cycle as a clear wins, so no event is lost.

Top module: `pcx_ctrl`

## Requirements
- R1: A change in either direction on pin_i[8*g+k] while bit k of group g's pin-enable register is one sets flag g (bit g of the flag register). The flag is readable after the third rising clock edge that follows the pin change.
- R2: irq_o[g] is one exactly when flag g, bit g of the group-enable register and gie_i are all one.
- R3: An ack_i[g] pulse clears flag g on the next clock edge, as long as no new enabled change occurs in that cycle.
- R4: A bus write to the flag register (address 0x69) clears each flag whose write-data bit is one. Flags whose write-data bit is zero keep their value.
- R5: A change on a pin whose enable bit is zero neither sets the flag nor raises a request.
- R6: The pin-enable registers of groups 0, 1 and 2 are at addresses 0x6B, 0x6C and 0x6D. They are read/write, reset to 0x00, and bit k of each enables pin k of that group.
- R7: Bit 7 of the group 1 pin-enable register ignores writes and always reads zero, so pin_i[15] never sets a flag.
- R8: The group-enable register (address 0x68, bits 2:0 for groups 0 to 2) and the flag register (address 0x69, same bit order) reset to zero. Their bits 7:3 always read zero.
- R9: When an enabled change and a clear (acknowledge or write-one) of the same flag happen in the same cycle, the flag is one afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 24 | Asynchronous pin levels; group g is bits 8g+7..8g |
| bus_addr_i | input | 8 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (zero for unmapped addresses) |
| ack_i | input | 3 | Per-group service acknowledge pulse |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
Single enabled pins are toggled upward and then back down, which separates any-edge detection from rising-only detection. Toggles on disabled pins, and on the reserved pin of the middle group, must leave every flag at zero. Wide toggles of whole groups show that the groups stay independent of one another. Directed sequences then walk the three-way request gate, the two kinds of clear including a write of zeros, and a clear landing in the same cycle as a fresh change.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    localparam int NGRP   = 3;
    localparam int GRP_W  = 8;
    localparam int PIN_W  = NGRP * GRP_W;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int GIDX_W = $clog2(NGRP);

    localparam logic [ADDR_W-1:0] MASK_BASE = 8'h6B;
    localparam logic [ADDR_W-1:0] EN_ADDR   = 8'h68;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 8'h69;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_EN,
        SEL_FLAG
    } sel_e;

    typedef struct packed {
        sel_e              kind;
        logic [GIDX_W-1:0] grp;
    } dec_t;

    // Group 1 owns only seven pins; its top enable bit is tied off.
    function automatic logic [GRP_W-1:0] valid_bits(input int g);
        return (g == 1) ? {1'b0, {(GRP_W-1){1'b1}}} : {GRP_W{1'b1}};
    endfunction

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t              d;
        logic [ADDR_W-1:0] off;
        off    = a - MASK_BASE;
        d.kind = SEL_NONE;
        d.grp  = '0;
        if (off < ADDR_W'(NGRP)) begin
            d.kind = SEL_MASK;
            d.grp  = off[GIDX_W-1:0];
        end else if (a == EN_ADDR) begin
            d.kind = SEL_EN;
        end else if (a == FLAG_ADDR) begin
            d.kind = SEL_FLAG;
        end
        return d;
    endfunction

endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;

endmodule

// File: rtl/pcx_group.sv
module pcx_group #(
    parameter int           W     = 8,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_s,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    input  logic         clr_wr,
    input  logic         ack,
    output logic [W-1:0] mask_q,
    output logic         flag_q
);

    logic [W-1:0] prev_q;
    logic [W-1:0] chg;
    logic         hit;
    logic         clr;

    assign chg = pin_s ^ prev_q;
    assign hit = |(chg & mask_q);
    assign clr = ack | clr_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            mask_q <= '0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (mask_we) begin
                mask_q <= wdata & VALID;
            end
            // a fresh event outranks any clear in the same cycle
            if (hit) begin
                flag_q <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assert_flag_set_R1: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    assert_ack_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> !flag_q);

    assert_wr_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !hit) |=> !flag_q);

    assert_only_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(hit));

    assert_mask_reset_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (mask_q & ~VALID) == '0);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (hit && clr) |=> flag_q);

endmodule

// File: rtl/pcx_ctrl.sv
module pcx_ctrl
    import pcx_pkg::*;
#(
    parameter int N  = NGRP,
    parameter int GW = GRP_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N*GW-1:0] pin_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic          bus_we_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic [N-1:0]  ack_i,
    input  logic          gie_i,
    output logic [N-1:0]  irq_o
);

    localparam int PW = N * GW;

    logic [PW-1:0] pin_s;
    logic [GW-1:0] mask_q [N];
    logic [N-1:0]  flag_q;
    logic [N-1:0]  en_q;
    dec_t          dec;

    assign dec = decode(bus_addr_i);

    pcx_sync #(.W(PW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_s)
    );

    for (genvar g = 0; g < N; g++) begin : g_grp
        logic mask_we;
        logic clr_wr;
        assign mask_we = bus_we_i && (dec.kind == SEL_MASK) && (dec.grp == GIDX_W'(g));
        assign clr_wr  = bus_we_i && (dec.kind == SEL_FLAG) && bus_wdata_i[g];

        pcx_group #(.W(GW), .VALID(valid_bits(g))) u_grp (
            .clk     (clk),
            .rst     (rst),
            .pin_s   (pin_s[g*GW +: GW]),
            .mask_we (mask_we),
            .wdata   (bus_wdata_i[GW-1:0]),
            .clr_wr  (clr_wr),
            .ack     (ack_i[g]),
            .mask_q  (mask_q[g]),
            .flag_q  (flag_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (bus_we_i && dec.kind == SEL_EN) begin
            en_q <= bus_wdata_i[N-1:0];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (dec.kind)
            SEL_MASK: begin
                for (int g = 0; g < N; g++) begin
                    if (dec.grp == GIDX_W'(g)) begin
                        bus_rdata_o[GW-1:0] = mask_q[g];
                    end
                end
            end
            SEL_EN:   bus_rdata_o[N-1:0] = en_q;
            SEL_FLAG: bus_rdata_o[N-1:0] = flag_q;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_o = gie_i ? (flag_q & en_q) : '0;

    assert_no_irq_without_gie_R2: assert property (@(posedge clk) disable iff (rst)
        !gie_i |-> (irq_o == '0));

    assert_ctrl_reset_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && flag_q == '0));

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == SEL_EN || dec.kind == SEL_FLAG) |-> (bus_rdata_o[DW-1:N] == '0));

endmodule

// File: tb/pcx_ctrl_test.sv
module pcx_ctrl_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  m0;
        logic [7:0]  m1;
        logic [7:0]  m2;
        logic [23:0] tog;
        logic [2:0]  exp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'h01, 8'h00, 8'h00, 24'h000001, 3'b001},  // rising, single pin
        '{8'h01, 8'h00, 8'h00, 24'h000001, 3'b001},  // falling back
        '{8'h01, 8'h00, 8'h00, 24'h000002, 3'b000},  // disabled neighbour
        '{8'h00, 8'h80, 8'h00, 24'h008000, 3'b000},  // reserved pin
        '{8'h00, 8'h40, 8'h00, 24'h004000, 3'b010},  // top real pin of group 1
        '{8'h00, 8'h00, 8'h80, 24'h800000, 3'b100},  // group 2 msb
        '{8'hFF, 8'hFF, 8'hFF, 24'hFFFFFF, 3'b111},  // everything
        '{8'h00, 8'h00, 8'h0F, 24'hF0FFFF, 3'b000},  // only disabled pins move
        '{8'h01, 8'h01, 8'h01, 24'h010101, 3'b111}   // one pin per group
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pins = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  ack = '0;
    logic        gie = 1'b0;
    logic [2:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcx_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pins),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .ack_i       (ack),
        .gie_i       (gie),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic toggle_settle(input logic [23:0] t);
        @(negedge clk);
        pins = pins ^ t;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state: R6, R8
        rd(8'h6B, v); check("R6 reset mask0", v, 8'h00);
        rd(8'h6C, v); check("R6 reset mask1", v, 8'h00);
        rd(8'h6D, v); check("R6 reset mask2", v, 8'h00);
        rd(8'h68, v); check("R8 reset enable", v, 8'h00);
        rd(8'h69, v); check("R8 reset flags", v, 8'h00);
        check("R2 reset irq", {5'b0, irq}, 8'h00);

        // register layout
        wr(8'h6B, 8'hA5); rd(8'h6B, v); check("R6 mask0 rw", v, 8'hA5);
        wr(8'h6D, 8'h3C); rd(8'h6D, v); check("R6 mask2 rw", v, 8'h3C);
        wr(8'h6C, 8'hFF); rd(8'h6C, v); check("R7 mask1 bit7 reads zero", v, 8'h7F);
        wr(8'h68, 8'hFF); rd(8'h68, v); check("R8 enable upper zero", v, 8'h07);
        wr(8'h68, 8'h00);

        // vector walk: R1, R5, R7
        for (int i = 0; i < NVEC; i++) begin
            wr(8'h6B, VECS[i].m0);
            wr(8'h6C, VECS[i].m1);
            wr(8'h6D, VECS[i].m2);
            wr(8'h69, 8'hFF);
            rd(8'h69, v); check($sformatf("R4 vec%0d pre-clear", i), v, 8'h00);
            toggle_settle(VECS[i].tog);
            rd(8'h69, v);
            check($sformatf("R1/R5/R7 vec%0d flags", i), v, {5'b0, VECS[i].exp});
        end
        rd(8'h69, v); check("R8 flag upper zero", v & 8'hF8, 8'h00);

        // request gate: R2
        wr(8'h6B, 8'h01); wr(8'h6C, 8'h00); wr(8'h6D, 8'h00);
        wr(8'h69, 8'h07);
        toggle_settle(24'h000001);
        gie = 1'b0; wr(8'h68, 8'h00);
        #1 check("R2 flag only", {5'b0, irq}, 8'h00);
        wr(8'h68, 8'h01);
        #1 check("R2 no gie", {5'b0, irq}, 8'h00);
        gie = 1'b1;
        #1 check("R2 all set", {5'b0, irq}, 8'h01);
        wr(8'h68, 8'h06);
        #1 check("R2 other groups enabled", {5'b0, irq}, 8'h00);
        wr(8'h68, 8'h07);

        // acknowledge: R3
        @(negedge clk); ack = 3'b001;
        @(negedge clk); ack = 3'b000;
        rd(8'h69, v); check("R3 ack clears", v, 8'h00);
        check("R3 irq drops", {5'b0, irq}, 8'h00);

        // write-one clear: R4
        toggle_settle(24'h000001);
        wr(8'h69, 8'h00); rd(8'h69, v); check("R4 zero keeps", v, 8'h01);
        wr(8'h69, 8'h06); rd(8'h69, v); check("R4 other bits keep", v, 8'h01);
        wr(8'h69, 8'h01); rd(8'h69, v); check("R4 one clears", v, 8'h00);

        // set wins over a clear in the same cycle: R9
        toggle_settle(24'h000001);
        @(negedge clk); pins = pins ^ 24'h000001;
        @(negedge clk);
        @(negedge clk);
        ack = 3'b001; addr = 8'h69; wdata = 8'h01; we = 1'b1;
        @(negedge clk);
        ack = 3'b000; we = 1'b0;
        rd(8'h69, v); check("R9 set beats clear", v, 8'h01);
        check("R9 irq held", {5'b0, irq}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule